// File: doc/BRIEF.md
# Exposed-Latency Execute Phase Tracker

This block follows instructions through the execute phases of a pipeline that has no interlocks. Each cycle one instruction may be issued into its first execute phase. It carries a kind code, a condition bit, a destination register index, a precomputed result value and an address. The block carries each live instruction forward one phase per clock. It raises the register write, memory request or fetch redirect at the phase fixed for that kind. A later instruction therefore sees an earlier result only once that instruction's delay slots are over, and nothing stalls.

The register file has three separate write ports. Port A carries single-cycle results in the issue cycle, port M carries multiply results one cycle later, and port L carries load data four cycles after issue. Writes from different instructions can therefore land in the same cycle. When two ports name the same register in one cycle, a clash flag goes high. Memory is a plain request output plus a read-data input that the block samples in the load's fourth phase.

Top module: `exe_phase_tracker`

## Requirements
- R1: An issued single-cycle instruction (kind code 1) with a true condition drives write port A in its issue cycle, with its destination index and value.
- R2: A multiply (kind code 2) with a true condition drives write port M one cycle after issue, with its destination index and value. No write occurs in the issue cycle.
- R3: A store (kind code 3) with a true condition raises the memory request with the write bit set one cycle after issue, carrying its address and value. It drives no register write port.
- R4: A load (kind code 4) with a true condition raises the memory request with the write bit clear one cycle after issue. The memory read data present three cycles after issue is written on port L to its destination four cycles after issue.
- R5: A branch (kind code 5) with a true condition pulses the redirect output for exactly one cycle, five cycles after issue, with its address as the target. Branches issued on consecutive cycles give redirects on consecutive cycles.
- R6: An instruction whose condition bit is false produces no register write, memory request or redirect in any cycle, including its issue cycle.
- R7: Kind code 0 (no-op) and the unused codes 6 and 7 produce no register write, memory request or redirect.
- R8: Instructions in flight proceed independently. Writes from different ports that fall in the same cycle all appear in that cycle.
- R9: The clash output is high in exactly those cycles in which two or more write ports are active with the same destination index.
- R10: A synchronous active-high reset clears every in-flight instruction. From the first cycle after reset, no write, memory request or redirect comes from an instruction issued before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction enters its first execute phase this cycle |
| iss_kind | input | 3 | Kind code: 0 no-op, 1 single-cycle, 2 multiply, 3 store, 4 load, 5 branch |
| iss_cond | input | 1 | Condition result; 0 cancels all activity |
| iss_dst | input | RIDX_W | Destination register index |
| iss_value | input | DATA_W | Result value, or store data |
| iss_addr | input | ADDR_W | Memory address or branch target |
| wb_a_valid | output | 1 | Single-cycle write strobe |
| wb_a_dst | output | RIDX_W | Single-cycle write index |
| wb_a_data | output | DATA_W | Single-cycle write data |
| wb_m_valid | output | 1 | Multiply write strobe |
| wb_m_dst | output | RIDX_W | Multiply write index |
| wb_m_data | output | DATA_W | Multiply write data |
| wb_l_valid | output | 1 | Load write strobe |
| wb_l_dst | output | RIDX_W | Load write index |
| wb_l_data | output | DATA_W | Load write data |
| mem_req | output | 1 | Memory request strobe |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Read data, sampled in the load's fourth phase |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_target | output | ADDR_W | Redirect target |
| wb_clash | output | 1 | Two or more write ports name the same register this cycle |

## Verification
The hardest case to reach from the ports is a cycle in which all three write ports fire at once. This needs a load issued four cycles before, a multiply issued one cycle before and a single-cycle instruction issued in the same cycle, with the read data held steady through the load's fourth phase. The bench times that sequence by hand, with the load and the single-cycle instruction sharing a destination, so the clash and the three-way write show up in one sampled cycle. A second sequence asserts reset while a branch and a load are still in flight, and then watches the cycles in which their effects would have appeared.

// File: rtl/exe_trk_pkg.sv
package exe_trk_pkg;

   localparam logic [2:0] KIND_NOP    = 3'd0;
   localparam logic [2:0] KIND_ALU    = 3'd1;
   localparam logic [2:0] KIND_MUL    = 3'd2;
   localparam logic [2:0] KIND_STORE  = 3'd3;
   localparam logic [2:0] KIND_LOAD   = 3'd4;
   localparam logic [2:0] KIND_BRANCH = 3'd5;

   // phase numbers: 1 is the issue phase
   localparam int PH_FIRST  = 1;
   localparam int PH_MEM    = 2;
   localparam int PH_MUL_WB = 2;
   localparam int PH_ST_ACC = 3;
   localparam int PH_LD_RET = 4;
   localparam int PH_LD_WB  = 5;
   localparam int PH_REDIR  = 6;
   localparam int PH_LAST   = 6;

   // last phase in which an instruction of this kind still has work
   function automatic int final_phase(logic [2:0] kind);
      case (kind)
         KIND_MUL:    return PH_MUL_WB;
         KIND_STORE:  return PH_ST_ACC;
         KIND_LOAD:   return PH_LD_WB;
         KIND_BRANCH: return PH_REDIR;
         default:     return PH_FIRST;
      endcase
   endfunction

endpackage

// File: rtl/exe_trk_issue.sv
module exe_trk_issue
   import exe_trk_pkg::*;
#(
   parameter int RIDX_W = 5,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic              iss_valid,
   input  logic [2:0]        iss_kind,
   input  logic              iss_cond,
   input  logic [RIDX_W-1:0] iss_dst,
   input  logic [DATA_W-1:0] iss_value,
   input  logic [ADDR_W-1:0] iss_addr,
   output logic              alu_valid,
   output logic [RIDX_W-1:0] alu_dst,
   output logic [DATA_W-1:0] alu_data,
   output logic              ent_valid,
   output logic [2:0]        ent_kind,
   output logic [RIDX_W-1:0] ent_dst,
   output logic [DATA_W-1:0] ent_value,
   output logic [ADDR_W-1:0] ent_addr
);

   logic live;

   assign live = iss_valid & iss_cond;

   // phase-1 write for single-cycle kinds
   assign alu_valid = live && (iss_kind == KIND_ALU);
   assign alu_dst   = iss_dst;
   assign alu_data  = iss_value;

   // only kinds with work past phase 1 enter the phase chain
   assign ent_valid = live && (final_phase(iss_kind) > PH_FIRST);
   assign ent_kind  = iss_kind;
   assign ent_dst   = iss_dst;
   assign ent_value = iss_value;
   assign ent_addr  = iss_addr;

endmodule

// File: rtl/exe_trk_stage.sv
module exe_trk_stage #(
   parameter int RIDX_W        = 5,
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 32,
   parameter bit CLEAR_PAYLOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              d_v,
   input  logic [2:0]        d_k,
   input  logic [RIDX_W-1:0] d_dst,
   input  logic [DATA_W-1:0] d_val,
   input  logic [ADDR_W-1:0] d_addr,
   output logic              q_v,
   output logic [2:0]        q_k,
   output logic [RIDX_W-1:0] q_dst,
   output logic [DATA_W-1:0] q_val,
   output logic [ADDR_W-1:0] q_addr
);

   always_ff @(posedge clk) begin
      if (rst) q_v <= 1'b0;
      else     q_v <= d_v;
   end

   generate
      if (CLEAR_PAYLOAD) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst) begin
               q_k    <= '0;
               q_dst  <= '0;
               q_val  <= '0;
               q_addr <= '0;
            end else begin
               q_k    <= d_k;
               q_dst  <= d_dst;
               q_val  <= d_val;
               q_addr <= d_addr;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            q_k    <= d_k;
            q_dst  <= d_dst;
            q_val  <= d_val;
            q_addr <= d_addr;
         end
      end
   endgenerate

endmodule

// File: rtl/exe_trk_pipe.sv
module exe_trk_pipe
   import exe_trk_pkg::*;
#(
   parameter int RIDX_W        = 5,
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 32,
   parameter bit CLEAR_PAYLOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ent_valid,
   input  logic [2:0]        ent_kind,
   input  logic [RIDX_W-1:0] ent_dst,
   input  logic [DATA_W-1:0] ent_value,
   input  logic [ADDR_W-1:0] ent_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_v,
   output logic [2:0]        mem_k,
   output logic [RIDX_W-1:0] mem_dst,
   output logic [DATA_W-1:0] mem_val,
   output logic [ADDR_W-1:0] mem_a,
   output logic              ldw_v,
   output logic [2:0]        ldw_k,
   output logic [RIDX_W-1:0] ldw_dst,
   output logic [DATA_W-1:0] ldw_val,
   output logic              rdr_v,
   output logic [2:0]        rdr_k,
   output logic [ADDR_W-1:0] rdr_a
);

   localparam int FIRST_SLOT = PH_FIRST + 1;

   logic              nx_v   [FIRST_SLOT:PH_LAST];
   logic [2:0]        nx_k   [FIRST_SLOT:PH_LAST];
   logic [RIDX_W-1:0] nx_dst [FIRST_SLOT:PH_LAST];
   logic [DATA_W-1:0] nx_val [FIRST_SLOT:PH_LAST];
   logic [ADDR_W-1:0] nx_a   [FIRST_SLOT:PH_LAST];
   logic              st_v   [FIRST_SLOT:PH_LAST];
   logic [2:0]        st_k   [FIRST_SLOT:PH_LAST];
   logic [RIDX_W-1:0] st_dst [FIRST_SLOT:PH_LAST];
   logic [DATA_W-1:0] st_val [FIRST_SLOT:PH_LAST];
   logic [ADDR_W-1:0] st_a   [FIRST_SLOT:PH_LAST];

   generate
      for (genvar p = FIRST_SLOT; p <= PH_LAST; p++) begin : g_ph
         if (p == FIRST_SLOT) begin : g_head
            assign nx_v[p]   = ent_valid;
            assign nx_k[p]   = ent_kind;
            assign nx_dst[p] = ent_dst;
            assign nx_val[p] = ent_value;
            assign nx_a[p]   = ent_addr;
         end else begin : g_body
            // an instruction leaves the chain once its last phase is done
            assign nx_v[p]   = st_v[p-1] && (final_phase(st_k[p-1]) >= p);
            assign nx_k[p]   = st_k[p-1];
            assign nx_dst[p] = st_dst[p-1];
            assign nx_a[p]   = st_a[p-1];
            if (p == PH_LD_RET + 1) begin : g_ret
               assign nx_val[p] = (st_k[p-1] == KIND_LOAD) ? mem_rdata : st_val[p-1];
            end else begin : g_pass
               assign nx_val[p] = st_val[p-1];
            end
         end

         exe_trk_stage #(
            .RIDX_W(RIDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
            .CLEAR_PAYLOAD(CLEAR_PAYLOAD)
         ) stage_i (
            .clk    (clk),
            .rst    (rst),
            .d_v    (nx_v[p]),
            .d_k    (nx_k[p]),
            .d_dst  (nx_dst[p]),
            .d_val  (nx_val[p]),
            .d_addr (nx_a[p]),
            .q_v    (st_v[p]),
            .q_k    (st_k[p]),
            .q_dst  (st_dst[p]),
            .q_val  (st_val[p]),
            .q_addr (st_a[p])
         );
      end
   endgenerate

   assign mem_v   = st_v[PH_MEM];
   assign mem_k   = st_k[PH_MEM];
   assign mem_dst = st_dst[PH_MEM];
   assign mem_val = st_val[PH_MEM];
   assign mem_a   = st_a[PH_MEM];

   assign ldw_v   = st_v[PH_LD_WB];
   assign ldw_k   = st_k[PH_LD_WB];
   assign ldw_dst = st_dst[PH_LD_WB];
   assign ldw_val = st_val[PH_LD_WB];

   assign rdr_v   = st_v[PH_REDIR];
   assign rdr_k   = st_k[PH_REDIR];
   assign rdr_a   = st_a[PH_REDIR];

   logic unused_tail;
   assign unused_tail = ^{st_dst[PH_LAST], st_val[PH_LAST]};

endmodule

// File: rtl/exe_trk_clash.sv
module exe_trk_clash #(
   parameter int NPORT  = 3,
   parameter int RIDX_W = 5
) (
   input  logic [NPORT-1:0]             wv,
   input  logic [NPORT-1:0][RIDX_W-1:0] wd,
   output logic                         clash
);

   localparam int NPAIR = NPORT * NPORT;

   logic [NPAIR-1:0] pair_hit;

   generate
      if (NPORT < 2) begin : g_bad_nport
         $error("exe_trk_clash: NPORT must be at least 2");
      end
      for (genvar i = 0; i < NPORT; i++) begin : g_i
         for (genvar j = 0; j < NPORT; j++) begin : g_j
            if (j > i) begin : g_cmp
               assign pair_hit[i*NPORT+j] = wv[i] & wv[j] & (wd[i] == wd[j]);
            end else begin : g_zero
               assign pair_hit[i*NPORT+j] = 1'b0;
            end
         end
      end
   endgenerate

   assign clash = |pair_hit;

endmodule

// File: rtl/exe_phase_tracker.sv
module exe_phase_tracker
   import exe_trk_pkg::*;
#(
   parameter int RIDX_W        = 5,
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 32,
   parameter bit CLEAR_PAYLOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              iss_valid,
   input  logic [2:0]        iss_kind,
   input  logic              iss_cond,
   input  logic [RIDX_W-1:0] iss_dst,
   input  logic [DATA_W-1:0] iss_value,
   input  logic [ADDR_W-1:0] iss_addr,
   output logic              wb_a_valid,
   output logic [RIDX_W-1:0] wb_a_dst,
   output logic [DATA_W-1:0] wb_a_data,
   output logic              wb_m_valid,
   output logic [RIDX_W-1:0] wb_m_dst,
   output logic [DATA_W-1:0] wb_m_data,
   output logic              wb_l_valid,
   output logic [RIDX_W-1:0] wb_l_dst,
   output logic [DATA_W-1:0] wb_l_data,
   output logic              mem_req,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              redir_valid,
   output logic [ADDR_W-1:0] redir_target,
   output logic              wb_clash
);

   localparam int NWB = 3;

   generate
      if (RIDX_W < 1 || DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("exe_phase_tracker: widths must be positive");
      end
   endgenerate

   logic              ent_valid;
   logic [2:0]        ent_kind;
   logic [RIDX_W-1:0] ent_dst;
   logic [DATA_W-1:0] ent_value;
   logic [ADDR_W-1:0] ent_addr;

   exe_trk_issue #(.RIDX_W(RIDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) issue_i (
      .iss_valid (iss_valid),
      .iss_kind  (iss_kind),
      .iss_cond  (iss_cond),
      .iss_dst   (iss_dst),
      .iss_value (iss_value),
      .iss_addr  (iss_addr),
      .alu_valid (wb_a_valid),
      .alu_dst   (wb_a_dst),
      .alu_data  (wb_a_data),
      .ent_valid (ent_valid),
      .ent_kind  (ent_kind),
      .ent_dst   (ent_dst),
      .ent_value (ent_value),
      .ent_addr  (ent_addr)
   );

   logic              mem_v, ldw_v, rdr_v;
   logic [2:0]        mem_k, ldw_k, rdr_k;
   logic [RIDX_W-1:0] mem_dst;
   logic [DATA_W-1:0] mem_val;
   logic [ADDR_W-1:0] mem_a;

   exe_trk_pipe #(
      .RIDX_W(RIDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .CLEAR_PAYLOAD(CLEAR_PAYLOAD)
   ) pipe_i (
      .clk       (clk),
      .rst       (rst),
      .ent_valid (ent_valid),
      .ent_kind  (ent_kind),
      .ent_dst   (ent_dst),
      .ent_value (ent_value),
      .ent_addr  (ent_addr),
      .mem_rdata (mem_rdata),
      .mem_v     (mem_v),
      .mem_k     (mem_k),
      .mem_dst   (mem_dst),
      .mem_val   (mem_val),
      .mem_a     (mem_a),
      .ldw_v     (ldw_v),
      .ldw_k     (ldw_k),
      .ldw_dst   (wb_l_dst),
      .ldw_val   (wb_l_data),
      .rdr_v     (rdr_v),
      .rdr_k     (rdr_k),
      .rdr_a     (redir_target)
   );

   // phase 2: multiply result and memory request share the same slot
   assign wb_m_valid = mem_v && (mem_k == KIND_MUL);
   assign wb_m_dst   = mem_dst;
   assign wb_m_data  = mem_val;

   assign mem_req    = mem_v && ((mem_k == KIND_STORE) || (mem_k == KIND_LOAD));
   assign mem_write  = mem_v && (mem_k == KIND_STORE);
   assign mem_addr   = mem_a;
   assign mem_wdata  = mem_val;

   // phase 5: load data into the register file
   assign wb_l_valid = ldw_v && (ldw_k == KIND_LOAD);

   // phase 6: end of the fifth delay slot of a branch
   assign redir_valid = rdr_v && (rdr_k == KIND_BRANCH);

   exe_trk_clash #(.NPORT(NWB), .RIDX_W(RIDX_W)) clash_i (
      .wv    ({wb_l_valid, wb_m_valid, wb_a_valid}),
      .wd    ({wb_l_dst, wb_m_dst, wb_a_dst}),
      .clash (wb_clash)
   );

endmodule

// File: rtl/exe_phase_tracker_chk.sv
module exe_phase_tracker_chk #(
   parameter int RIDX_W = 5,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              iss_valid,
   input logic [2:0]        iss_kind,
   input logic              iss_cond,
   input logic [RIDX_W-1:0] iss_dst,
   input logic [DATA_W-1:0] iss_value,
   input logic [ADDR_W-1:0] iss_addr,
   input logic              wb_a_valid,
   input logic [RIDX_W-1:0] wb_a_dst,
   input logic [DATA_W-1:0] wb_a_data,
   input logic              wb_m_valid,
   input logic [RIDX_W-1:0] wb_m_dst,
   input logic [DATA_W-1:0] wb_m_data,
   input logic              wb_l_valid,
   input logic [RIDX_W-1:0] wb_l_dst,
   input logic [DATA_W-1:0] wb_l_data,
   input logic              mem_req,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              redir_valid,
   input logic [ADDR_W-1:0] redir_target,
   input logic              wb_clash
);

   assert_alu_wb_R1: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_cond && iss_kind == 3'd1)
      |-> (wb_a_valid && wb_a_dst == iss_dst && wb_a_data == iss_value));

   assert_mul_wb_R2: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_cond && iss_kind == 3'd2)
      |=> (wb_m_valid && wb_m_dst == $past(iss_dst) && wb_m_data == $past(iss_value)));

   assert_store_req_R3: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_cond && iss_kind == 3'd3)
      |=> (mem_req && mem_write && mem_addr == $past(iss_addr)
           && mem_wdata == $past(iss_value)));

   assert_load_req_R4: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_cond && iss_kind == 3'd4)
      |=> (mem_req && !mem_write && mem_addr == $past(iss_addr)));

   assert_load_data_R4: assert property (@(posedge clk) disable iff (rst)
      wb_l_valid |-> (wb_l_data == $past(mem_rdata)));

   assert_redir_src_R5: assert property (@(posedge clk) disable iff (rst)
      redir_valid
      |-> ($past(iss_valid && iss_cond && iss_kind == 3'd5, 5)
           && redir_target == $past(iss_addr, 5)));

   assert_false_cond_R6: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && !iss_cond) |-> !wb_a_valid);

   assert_clash_hit_R9: assert property (@(posedge clk) disable iff (rst)
      (wb_m_valid && wb_l_valid && wb_m_dst == wb_l_dst) |-> wb_clash);

   assert_clash_need_R9: assert property (@(posedge clk) disable iff (rst)
      wb_clash |-> ($countones({wb_a_valid, wb_m_valid, wb_l_valid}) >= 2));

   assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!wb_m_valid && !wb_l_valid && !mem_req && !redir_valid));

endmodule

bind exe_phase_tracker exe_phase_tracker_chk #(
   .RIDX_W(RIDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
   .clk          (clk),
   .rst          (rst),
   .iss_valid    (iss_valid),
   .iss_kind     (iss_kind),
   .iss_cond     (iss_cond),
   .iss_dst      (iss_dst),
   .iss_value    (iss_value),
   .iss_addr     (iss_addr),
   .wb_a_valid   (wb_a_valid),
   .wb_a_dst     (wb_a_dst),
   .wb_a_data    (wb_a_data),
   .wb_m_valid   (wb_m_valid),
   .wb_m_dst     (wb_m_dst),
   .wb_m_data    (wb_m_data),
   .wb_l_valid   (wb_l_valid),
   .wb_l_dst     (wb_l_dst),
   .wb_l_data    (wb_l_data),
   .mem_req      (mem_req),
   .mem_write    (mem_write),
   .mem_addr     (mem_addr),
   .mem_wdata    (mem_wdata),
   .mem_rdata    (mem_rdata),
   .redir_valid  (redir_valid),
   .redir_target (redir_target),
   .wb_clash     (wb_clash)
);

// File: tb/exe_phase_tracker_tb_top.sv
`timescale 1ns/1ps
module exe_phase_tracker_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        iss_valid;
   logic [2:0]  iss_kind;
   logic        iss_cond;
   logic [4:0]  iss_dst;
   logic [31:0] iss_value;
   logic [31:0] iss_addr;
   logic        wb_a_valid, wb_m_valid, wb_l_valid;
   logic [4:0]  wb_a_dst, wb_m_dst, wb_l_dst;
   logic [31:0] wb_a_data, wb_m_data, wb_l_data;
   logic        mem_req, mem_write;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        redir_valid;
   logic [31:0] redir_target;
   logic        wb_clash;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   exe_phase_tracker dut_i (
      .clk(clk), .rst(rst),
      .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_cond(iss_cond),
      .iss_dst(iss_dst), .iss_value(iss_value), .iss_addr(iss_addr),
      .wb_a_valid(wb_a_valid), .wb_a_dst(wb_a_dst), .wb_a_data(wb_a_data),
      .wb_m_valid(wb_m_valid), .wb_m_dst(wb_m_dst), .wb_m_data(wb_m_data),
      .wb_l_valid(wb_l_valid), .wb_l_dst(wb_l_dst), .wb_l_data(wb_l_data),
      .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .redir_valid(redir_valid), .redir_target(redir_target),
      .wb_clash(wb_clash)
   );

   typedef struct packed {
      logic [2:0]  kind;
      logic        cond;
      logic [4:0]  dst;
      logic [31:0] val;
      logic [31:0] addr;
      logic [31:0] rdata;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{3'd1, 1'b1, 5'd3,  32'hA5A5_0001, 32'h0000_0000, 32'h0000_0000},
      '{3'd2, 1'b1, 5'd4,  32'h0000_BEEF, 32'h0000_0000, 32'h0000_0000},
      '{3'd3, 1'b1, 5'd0,  32'hDEAD_0002, 32'h0000_1000, 32'h0000_0000},
      '{3'd4, 1'b1, 5'd6,  32'h0000_0000, 32'h0000_2000, 32'hCAFE_F00D},
      '{3'd5, 1'b1, 5'd0,  32'h0000_0000, 32'h0000_8040, 32'h0000_0000},
      '{3'd1, 1'b0, 5'd3,  32'h1234_5678, 32'h0000_0000, 32'h0000_0000},
      '{3'd4, 1'b0, 5'd6,  32'h0000_0000, 32'h0000_2004, 32'h7777_7777},
      '{3'd5, 1'b0, 5'd0,  32'h0000_0000, 32'h0000_9000, 32'h0000_0000},
      '{3'd0, 1'b1, 5'd8,  32'h0000_0011, 32'h0000_3000, 32'h0000_0000},
      '{3'd7, 1'b1, 5'd9,  32'h0000_0022, 32'h0000_3004, 32'h0000_0000},
      '{3'd3, 1'b0, 5'd0,  32'h0BAD_0BAD, 32'h0000_1004, 32'h0000_0000},
      '{3'd2, 1'b1, 5'd31, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
      '{3'd1, 1'b1, 5'd0,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(vec_t v);
      if (!v.cond) return "R6";
      case (v.kind)
         3'd1:    return "R1";
         3'd2:    return "R2";
         3'd3:    return "R3";
         3'd4:    return "R4";
         3'd5:    return "R5";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [6:0] activity();
      return {wb_a_valid, wb_m_valid, wb_l_valid, mem_req, mem_write, redir_valid, wb_clash};
   endfunction

   task automatic drive(input logic [2:0] k, input logic c, input logic [4:0] d,
                        input logic [31:0] v, input logic [31:0] a);
      iss_valid = 1'b1; iss_kind = k; iss_cond = c;
      iss_dst = d; iss_value = v; iss_addr = a;
   endtask

   task automatic idle();
      iss_valid = 1'b0; iss_kind = 3'd0; iss_cond = 1'b0;
   endtask

   task automatic run_vec(input int idx, input vec_t v);
      logic [6:0] ea;
      string tg;
      tg = tag_of(v);
      @(negedge clk);
      mem_rdata = v.rdata;
      drive(v.kind, v.cond, v.dst, v.val, v.addr);
      for (int c = 0; c < 7; c++) begin
         if (c > 0) begin
            @(negedge clk);
            idle();
         end
         #2;
         ea[6] = v.cond && c == 0 && v.kind == 3'd1;
         ea[5] = v.cond && c == 1 && v.kind == 3'd2;
         ea[4] = v.cond && c == 4 && v.kind == 3'd4;
         ea[3] = v.cond && c == 1 && (v.kind == 3'd3 || v.kind == 3'd4);
         ea[2] = v.cond && c == 1 && v.kind == 3'd3;
         ea[1] = v.cond && c == 5 && v.kind == 3'd5;
         ea[0] = 1'b0;
         chk(activity() == ea, tg, $sformatf("activity vec %0d cycle %0d", idx, c),
             64'(activity()), 64'(ea));
         if (ea[6])
            chk({wb_a_dst, wb_a_data} == {v.dst, v.val}, tg, "port A dst/data",
                64'({wb_a_dst, wb_a_data}), 64'({v.dst, v.val}));
         if (ea[5])
            chk({wb_m_dst, wb_m_data} == {v.dst, v.val}, tg, "port M dst/data",
                64'({wb_m_dst, wb_m_data}), 64'({v.dst, v.val}));
         if (ea[3])
            chk(mem_addr == v.addr, tg, "memory address", 64'(mem_addr), 64'(v.addr));
         if (ea[2])
            chk(mem_wdata == v.val, tg, "store data", 64'(mem_wdata), 64'(v.val));
         if (ea[4])
            chk({wb_l_dst, wb_l_data} == {v.dst, v.rdata}, tg, "port L dst/data",
                64'({wb_l_dst, wb_l_data}), 64'({v.dst, v.rdata}));
         if (ea[1])
            chk(redir_target == v.addr, tg, "redirect target",
                64'(redir_target), 64'(v.addr));
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL all watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst = 1'b1;
      mem_rdata = '0;
      iss_dst = '0; iss_value = '0; iss_addr = '0;
      idle();
      repeat (3) @(negedge clk);
      #2;
      // R10: reset state
      chk(activity() == 7'b0, "R10", "outputs under reset", 64'(activity()), 64'd0);
      @(negedge clk);
      rst = 1'b0;
      #2;
      chk(activity() == 7'b0, "R10", "outputs after reset", 64'(activity()), 64'd0);

      for (int i = 0; i < NVEC; i++) run_vec(i, VECS[i]);

      // R8/R9: load (t), multiply (t+3), single-cycle (t+4) all write at t+4
      @(negedge clk);
      mem_rdata = 32'h0BAD_F00D;
      drive(3'd4, 1'b1, 5'd7, 32'h0, 32'h0000_0300);
      @(negedge clk); idle();
      @(negedge clk);
      @(negedge clk); drive(3'd2, 1'b1, 5'd9, 32'h0000_0099, 32'h0);
      @(negedge clk); drive(3'd1, 1'b1, 5'd7, 32'h0000_0077, 32'h0);
      #2;
      chk(activity() == 7'b1110001, "R8", "three ports in one cycle",
          64'(activity()), 64'(7'b1110001));
      chk({wb_l_dst, wb_l_data} == {5'd7, 32'h0BAD_F00D}, "R8", "load port in overlap",
          64'({wb_l_dst, wb_l_data}), 64'({5'd7, 32'h0BAD_F00D}));
      chk({wb_m_dst, wb_m_data} == {5'd9, 32'h0000_0099}, "R8", "mul port in overlap",
          64'({wb_m_dst, wb_m_data}), 64'({5'd9, 32'h0000_0099}));
      chk(wb_clash == 1'b1, "R9", "clash on shared dst", 64'(wb_clash), 64'd1);
      @(negedge clk); idle();
      #2;
      chk(activity() == 7'b0, "R9", "quiet after overlap", 64'(activity()), 64'd0);

      // R8/R9: multiply then single-cycle, different and equal dst
      @(negedge clk); drive(3'd2, 1'b1, 5'd4, 32'h0000_0044, 32'h0);
      @(negedge clk); drive(3'd1, 1'b1, 5'd5, 32'h0000_0055, 32'h0);
      #2;
      chk(activity() == 7'b1100000, "R8", "mul and alu distinct dst",
          64'(activity()), 64'(7'b1100000));
      chk(wb_clash == 1'b0, "R9", "no clash on distinct dst", 64'(wb_clash), 64'd0);
      @(negedge clk); drive(3'd2, 1'b1, 5'd8, 32'h0000_0088, 32'h0);
      @(negedge clk); drive(3'd1, 1'b1, 5'd8, 32'h0000_0018, 32'h0);
      #2;
      chk(activity() == 7'b1100001, "R9", "mul and alu same dst",
          64'(activity()), 64'(7'b1100001));
      @(negedge clk); idle();

      // R10: reset while a branch and a load are in flight
      @(negedge clk); drive(3'd5, 1'b1, 5'd0, 32'h0, 32'h0000_4444);
      @(negedge clk); drive(3'd4, 1'b1, 5'd10, 32'h0, 32'h0000_0500);
      mem_rdata = 32'h5555_AAAA;
      @(negedge clk); idle(); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      for (int c = 0; c < 6; c++) begin
         #2;
         chk(activity() == 7'b0, "R10", $sformatf("flushed cycle %0d", c),
             64'(activity()), 64'd0);
         @(negedge clk);
      end

      // R5/R6: back-to-back branches, then a cancelled one
      for (int c = 0; c < 9; c++) begin
         if (c > 0) @(negedge clk);
         case (c)
            0: drive(3'd5, 1'b1, 5'd0, 32'h0, 32'h0000_A000);
            1: drive(3'd5, 1'b1, 5'd0, 32'h0, 32'h0000_B000);
            2: drive(3'd5, 1'b0, 5'd0, 32'h0, 32'h0000_C000);
            default: idle();
         endcase
         #2;
         chk(redir_valid == (c == 5 || c == 6), (c == 7) ? "R6" : "R5",
             $sformatf("redirect pulse cycle %0d", c),
             64'(redir_valid), 64'(c == 5 || c == 6));
         if (c == 5)
            chk(redir_target == 32'h0000_A000, "R5", "first target",
                64'(redir_target), 64'h0000_A000);
         if (c == 6)
            chk(redir_target == 32'h0000_B000, "R5", "second target",
                64'(redir_target), 64'h0000_B000);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule